// File: doc/BRIEF.md
# Table-Driven Multi-Channel Software Timer Scanner

This block keeps sixteen software timers in a small internal table and services them with one shared sequential engine rather than sixteen parallel counters. Each pulse on the tick input starts one pass over the table. The engine visits one entry per clock cycle. For every entry marked valid, it counts the entry down by one. When an entry reaches zero, the engine flags an event for that timer. A per-entry restart bit then decides what happens next: the entry is either reloaded from its initial count or retired.

A host programs entries through a single-cycle command port. Each command names a timer and carries an enable flag, a restart flag and an initial count. A command changes the table at once, but it never starts a pass by itself, so the change is first seen at the next tick. Event bits are sticky and are cleared by writing ones to them. A mask register selects which events drive the interrupt output. A pass counter advances at the end of every completed pass.

Top module: `swtmr_scan`

## Requirements
- R1: After reset, the event, valid and restart bitmaps, the mask and the pass counter are all zero, and irq is low.
- R2: An enable command (cmdEnable=1) sets the entry's valid bit and loads both its initial and current count with cmdInit. An entry loaded with N (N>0) sets its event bit during the Nth pass after the command and not before.
- R3: An entry whose valid bit is clear is skipped: its count does not change and its event bit is never set by a pass. A command with cmdEnable=0 clears the entry's valid bit.
- R4: On expiry of an entry whose restart bit is 0, the valid bit of that entry is cleared and no further events come from it.
- R5: On expiry of an entry whose restart bit is 1, the valid bit stays set and the count is reloaded, so the event recurs every N passes.
- R6: The pass counter increments by exactly one per completed pass. It changes on the 16th rising edge after the edge that samples tickIn high, because entry k (0..15) is serviced on edge k+1.
- R7: A command never starts a pass. Without a tick, the pass counter and the events stay unchanged after any number of commands.
- R8: A tick sampled while a pass is running is held pending, and a second pass begins immediately after the first, with no idle cycle between them. Several ticks that arrive during one pass merge into a single pending pass.
- R9: Writing clrWe=1 clears every event bit set in clrBits, and no other event bit. If the engine sets a bit in the same cycle as a clear of that bit, the set wins.
- R10: irq is high exactly when some event bit is set whose mask bit is also set. maskWe=1 loads the mask from maskBits.
- R11: An initial count of 0 means 2^CNT_W passes until expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Timebase tick that requests one table pass |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdIdx | input | 4 | Timer index addressed by the command |
| cmdEnable | input | 1 | 1 enables and loads the entry, 0 disables it |
| cmdRestart | input | 1 | Restart (periodic) flag for the entry |
| cmdInit | input | CNT_W (16) | Initial count, 0 meaning 2^CNT_W |
| clrWe | input | 1 | Write strobe for clearing events |
| clrBits | input | 16 | Ones clear the matching event bits |
| maskWe | input | 1 | Write strobe for the interrupt mask |
| maskBits | input | 16 | New interrupt mask value |
| eventReg | output | 16 | Sticky per-timer expiry flags |
| validMap | output | 16 | Per-timer valid bitmap |
| restartMap | output | 16 | Per-timer restart bitmap |
| scanCount | output | SCAN_W (16) | Completed pass counter |
| irq | output | 1 | OR of masked event bits |

## Verification
Two functions can act on one event bit in the same cycle: the engine setting that bit as its entry expires, and a host write that clears it. The bench arms a single one-shot entry with a count of 1 and issues a tick. It then places a clear strobe on exactly the cycle in which that entry is serviced, and the same clear also names another event bit that is already set. The clear is judged correct if the bit being set stays set, the other named bit is cleared, and the pass counter and a reference model of the table agree afterwards.

// File: rtl/swtmr_pkg.sv
package swtmr_pkg;
  localparam int TMR_NUM = 16;
  localparam int IDX_W = $clog2(TMR_NUM);

  // Strobes from the scan sequencer to the table datapath
  typedef struct packed {
    logic             procEn;   // an entry is being serviced this cycle
    logic [IDX_W-1:0] idx;      // which entry
    logic             passDone; // last entry of the pass
  } scanStb_t;
endpackage

// File: rtl/swtmr_ctrl.sv
module swtmr_ctrl
  import swtmr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickIn,
  output scanStb_t stb
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TMR_NUM - 1);

  logic             busy;
  logic             pending;
  logic [IDX_W-1:0] idx;
  logic             lastEnt;

  assign lastEnt = busy && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pending <= 1'b0;
      idx     <= '0;
    end else if (!busy) begin
      if (tickIn) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (lastEnt) begin
      idx <= '0;
      if (pending || tickIn) pending <= 1'b0;
      else                   busy    <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
      if (tickIn) pending <= 1'b1;
    end
  end

  always_comb begin
    stb.procEn   = busy;
    stb.idx      = idx;
    stb.passDone = lastEnt;
  end

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !tickIn) |=> !busy); // R7
  AST_PEND_SERVE: assert property (@(posedge clk) disable iff (!rstN)
    (lastEnt && pending) |=> (busy && idx == '0)); // R8
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1)); // R6
endmodule

// File: rtl/swtmr_dp.sv
module swtmr_dp
  import swtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SCAN_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStb_t           stb,
  input  logic               cmdValid,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic               cmdEnable,
  input  logic               cmdRestart,
  input  logic [CNT_W-1:0]   cmdInit,
  input  logic               clrWe,
  input  logic [TMR_NUM-1:0] clrBits,
  input  logic               maskWe,
  input  logic [TMR_NUM-1:0] maskBits,
  output logic [TMR_NUM-1:0] eventReg,
  output logic [TMR_NUM-1:0] validMap,
  output logic [TMR_NUM-1:0] restartMap,
  output logic [SCAN_W-1:0]  scanCount,
  output logic               irq
);
  logic [CNT_W-1:0]   initMem [TMR_NUM];
  logic [CNT_W-1:0]   curMem  [TMR_NUM];
  logic [TMR_NUM-1:0] maskReg;
  logic [CNT_W-1:0]   curRd;
  logic [CNT_W-1:0]   decVal;
  logic               hit;
  logic               expire;
  logic [TMR_NUM-1:0] evtNx, validNx, restartNx;

  assign curRd  = curMem[stb.idx];
  assign decVal = curRd - 1'b1;
  assign hit    = stb.procEn && validMap[stb.idx];
  assign expire = hit && (decVal == '0);

  // Table: the scan write comes first, so a command to the same entry overrides it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TMR_NUM; i++) begin
        initMem[i] <= '0;
        curMem[i]  <= '0;
      end
    end else begin
      if (hit)
        curMem[stb.idx] <= (expire && restartMap[stb.idx]) ? initMem[stb.idx] : decVal;
      if (cmdValid && cmdEnable) begin
        initMem[cmdIdx] <= cmdInit;
        curMem[cmdIdx]  <= cmdInit;
      end
    end
  end

  always_comb begin
    evtNx     = eventReg;
    validNx   = validMap;
    restartNx = restartMap;
    if (clrWe) evtNx = evtNx & ~clrBits;
    if (expire) begin
      evtNx[stb.idx] = 1'b1;
      if (!restartMap[stb.idx]) validNx[stb.idx] = 1'b0;
    end
    if (cmdValid) begin
      validNx[cmdIdx]   = cmdEnable;
      restartNx[cmdIdx] = cmdRestart;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventReg   <= '0;
      validMap   <= '0;
      restartMap <= '0;
      maskReg    <= '0;
      scanCount  <= '0;
    end else begin
      eventReg   <= evtNx;
      validMap   <= validNx;
      restartMap <= restartNx;
      if (maskWe)       maskReg   <= maskBits;
      if (stb.passDone) scanCount <= scanCount + 1'b1;
    end
  end

  assign irq = |(eventReg & maskReg);

  AST_PASS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    stb.passDone |=> (scanCount == $past(scanCount) + 1'b1)); // R6
  AST_VALID_ONLY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ((validMap & ~$past(validMap)) == '0)); // R3
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrWe |=> (($past(eventReg) & ~eventReg) == '0)); // R9
  AST_RETIRE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ((($past(validMap) & ~validMap) & ~eventReg) == '0)); // R4
endmodule

// File: rtl/swtmr_scan.sv
module swtmr_scan
  import swtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SCAN_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickIn,
  input  logic               cmdValid,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic               cmdEnable,
  input  logic               cmdRestart,
  input  logic [CNT_W-1:0]   cmdInit,
  input  logic               clrWe,
  input  logic [TMR_NUM-1:0] clrBits,
  input  logic               maskWe,
  input  logic [TMR_NUM-1:0] maskBits,
  output logic [TMR_NUM-1:0] eventReg,
  output logic [TMR_NUM-1:0] validMap,
  output logic [TMR_NUM-1:0] restartMap,
  output logic [SCAN_W-1:0]  scanCount,
  output logic               irq
);
  scanStb_t stb;

  swtmr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickIn (tickIn),
    .stb    (stb)
  );

  swtmr_dp #(.CNT_W(CNT_W), .SCAN_W(SCAN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmdValid   (cmdValid),
    .cmdIdx     (cmdIdx),
    .cmdEnable  (cmdEnable),
    .cmdRestart (cmdRestart),
    .cmdInit    (cmdInit),
    .clrWe      (clrWe),
    .clrBits    (clrBits),
    .maskWe     (maskWe),
    .maskBits   (maskBits),
    .eventReg   (eventReg),
    .validMap   (validMap),
    .restartMap (restartMap),
    .scanCount  (scanCount),
    .irq        (irq)
  );
endmodule

// File: tb/swtmr_scan_bench.sv
module swtmr_scan_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdIdx = '0;
  logic cmdEnable = 1'b0;
  logic cmdRestart = 1'b0;
  logic [CW-1:0] cmdInit = '0;
  logic clrWe = 1'b0;
  logic [15:0] clrBits = '0;
  logic maskWe = 1'b0;
  logic [15:0] maskBits = '0;
  logic [15:0] eventReg, validMap, restartMap, scanCount;
  logic irq;

  always #4 clk = ~clk;

  swtmr_scan #(.CNT_W(CW), .SCAN_W(16)) u_swtmr_scan (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .cmdValid(cmdValid), .cmdIdx(cmdIdx),
    .cmdEnable(cmdEnable), .cmdRestart(cmdRestart), .cmdInit(cmdInit),
    .clrWe(clrWe), .clrBits(clrBits), .maskWe(maskWe), .maskBits(maskBits),
    .eventReg(eventReg), .validMap(validMap), .restartMap(restartMap),
    .scanCount(scanCount), .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // Reference model of the table
  logic [CW-1:0] mInit [16];
  logic [CW-1:0] mCur  [16];
  logic [15:0] mValid = '0, mRest = '0, mEvt = '0, mScan = '0;

  typedef struct packed { logic [15:0] sc; logic [15:0] ev; logic [15:0] va; } expItem_t;
  expItem_t expQ[$];
  logic [15:0] lastScan = '0;
  bit monOn = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scanModel();
    for (int i = 0; i < 16; i++) begin
      if (mValid[i]) begin
        mCur[i] = mCur[i] - 1'b1;
        if (mCur[i] == '0) begin
          mEvt[i] = 1'b1;
          if (mRest[i]) mCur[i] = mInit[i];
          else mValid[i] = 1'b0;
        end
      end
    end
    mScan = mScan + 1'b1;
    expQ.push_back('{sc: mScan, ev: mEvt, va: mValid});
  endtask

  // Monitor: compare at every completed pass (R2 R3 R4 R5 R6 R11)
  always @(negedge clk) begin
    if (monOn && scanCount !== lastScan) begin
      lastScan = scanCount;
      if (expQ.size() == 0) begin
        chk("R6 unexpected pass", {16'h0, scanCount}, 32'hFFFF);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk("R6 scoreboard count", {16'h0, scanCount}, {16'h0, e.sc});
        chk("R2 R5 R11 scoreboard events", {16'h0, eventReg}, {16'h0, e.ev});
        chk("R3 R4 scoreboard valid", {16'h0, validMap}, {16'h0, e.va});
      end
    end
  end

  task automatic doCmd(input int idx, input bit en, input bit rs, input logic [CW-1:0] init);
    @(negedge clk);
    cmdValid = 1'b1; cmdIdx = 4'(idx); cmdEnable = en; cmdRestart = rs; cmdInit = init;
    @(negedge clk);
    cmdValid = 1'b0;
    mValid[idx] = en; mRest[idx] = rs;
    if (en) begin mInit[idx] = init; mCur[idx] = init; end
    @(negedge clk);
  endtask

  task automatic doClear(input logic [15:0] bits);
    @(negedge clk);
    clrWe = 1'b1; clrBits = bits;
    @(negedge clk);
    clrWe = 1'b0;
    mEvt = mEvt & ~bits;
  endtask

  task automatic doMask(input logic [15:0] bits);
    @(negedge clk);
    maskWe = 1'b1; maskBits = bits;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    scanModel();
    repeat (18) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mInit[i] = '0; mCur[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 events", {16'h0, eventReg}, 32'h0);
    chk("R1 valid", {16'h0, validMap}, 32'h0);
    chk("R1 restart", {16'h0, restartMap}, 32'h0);
    chk("R1 pass count", {16'h0, scanCount}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    monOn = 1'b1;

    // Program entries; commands alone must not scan (R7)
    doCmd(0, 1'b1, 1'b0, 8'd3);
    doCmd(1, 1'b1, 1'b1, 8'd2);
    doCmd(5, 1'b1, 1'b1, 8'd1);
    doCmd(5, 1'b0, 1'b1, 8'd1);
    repeat (20) @(negedge clk);
    chk("R7 no pass from commands", {16'h0, scanCount}, 32'h0);
    chk("R7 no events from commands", {16'h0, eventReg}, 32'h0);
    chk("R2 R3 valid after commands", {16'h0, validMap}, 32'h0003);
    chk("R5 restart map", {16'h0, restartMap}, 32'h0022);

    // R2: entry 0 (N=3) quiet on passes 1 and 2, fires on pass 3
    doTick();
    chk("R2 entry0 quiet pass1", {31'h0, eventReg[0]}, 32'h0);
    doTick();
    chk("R2 entry0 quiet pass2", {31'h0, eventReg[0]}, 32'h0);
    chk("R5 entry1 fires pass2", {31'h0, eventReg[1]}, 32'h1);
    doTick();
    chk("R2 entry0 fires pass3", {31'h0, eventReg[0]}, 32'h1);
    chk("R4 entry0 retired", {31'h0, validMap[0]}, 32'h0);
    chk("R3 disabled entry5 silent", {31'h0, eventReg[5]}, 32'h0);
    doClear(16'h0002);
    doTick();
    chk("R5 entry1 refires pass4", {31'h0, eventReg[1]}, 32'h1);
    chk("R5 entry1 stays valid", {31'h0, validMap[1]}, 32'h1);

    // R10 mask / irq, R9 clear
    chk("R10 irq masked off", {31'h0, irq}, 32'h0);
    doMask(16'h0001);
    chk("R10 irq via bit0", {31'h0, irq}, 32'h1);
    doMask(16'h0010);
    chk("R10 irq unmasked bit empty", {31'h0, irq}, 32'h0);
    doMask(16'h0001);
    doClear(16'h0001);
    chk("R9 bit0 cleared", {16'h0, eventReg}, 32'h0002);
    chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);

    // R6 / R8 timing: second tick during pass is held pending
    begin
      logic [15:0] base;
      base = scanCount;
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
      scanModel();
      repeat (4) @(negedge clk);
      tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
      tickIn = 1'b1; // second pending tick in the same pass merges
      @(negedge clk); tickIn = 1'b0;
      scanModel();
      repeat (9) @(negedge clk);
      chk("R6 count before 16th edge", {16'h0, scanCount}, {16'h0, base});
      @(negedge clk);
      chk("R6 count at 16th edge", {16'h0, scanCount}, {16'h0, base + 16'd1});
      repeat (15) @(negedge clk);
      chk("R8 second pass not done early", {16'h0, scanCount}, {16'h0, base + 16'd1});
      @(negedge clk);
      chk("R8 pending pass back to back", {16'h0, scanCount}, {16'h0, base + 16'd2});
      repeat (20) @(negedge clk);
      chk("R8 merged ticks give one pass", {16'h0, scanCount}, {16'h0, base + 16'd2});
    end

    // R9 collision: set of bit2 and clear of bits 2,1 in the same cycle
    doCmd(1, 1'b0, 1'b0, 8'd0);
    doCmd(2, 1'b1, 1'b0, 8'd1);
    if (eventReg[1] !== 1'b1) begin
      doCmd(1, 1'b1, 1'b0, 8'd1);
      doTick();
    end
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    repeat (2) @(negedge clk);
    clrWe = 1'b1; clrBits = 16'h0006;
    @(negedge clk); clrWe = 1'b0;
    mEvt = mEvt & ~16'h0006;
    scanModel();
    repeat (18) @(negedge clk);
    chk("R9 set wins over clear", {31'h0, eventReg[2]}, 32'h1);
    chk("R9 other bit cleared", {31'h0, eventReg[1]}, 32'h0);

    // R11: initial count 0 lasts 2^CNT_W passes
    doCmd(7, 1'b1, 1'b0, 8'd0);
    for (int t = 0; t < 255; t++) doTick();
    chk("R11 not expired after 255", {31'h0, eventReg[7]}, 32'h0);
    chk("R11 still valid after 255", {31'h0, validMap[7]}, 32'h1);
    doTick();
    chk("R11 expired at 256", {31'h0, eventReg[7]}, 32'h1);
    chk("R11 retired at 256", {31'h0, validMap[7]}, 32'h0);

    chk("R6 scoreboard drained", expQ.size(), 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule